// File: doc/BRIEF.md
# Mode-Selectable Shift Register

A three-bit register whose action on every rising clock edge is picked by a two-bit mode input. The four actions are: clear to zero, shift one place toward bit 0, shift one place toward the top bit, and keep the current value. The clear is one of the four mode codes, so the block has no reset pin. After power-up its contents are undefined until the first clock edge with the clear mode.

Each shift direction has its own serial input. A shift toward bit 0 fills the top bit from the right-going serial input. A shift toward the top bit fills bit 0 from the left-going serial input. The parallel value is always visible. Two tap outputs show the end bits, which are the bits the next shift in each direction will drop. A user converts a serial stream to parallel by clocking three bits into one serial input under a shift mode and then reading the parallel output.

Top module: `mode_shift_reg`

## Requirements
- R1: With mode 2'b00 (mode[1] is S1, mode[0] is S0), the register is 3'b000 after the next rising edge, whatever its previous value and serial inputs.
- R2: With mode 2'b01, after the next rising edge bit 2 equals ser_right_i, bit 1 equals the old bit 2 and bit 0 equals the old bit 1.
- R3: With mode 2'b10, after the next rising edge bit 0 equals ser_left_i, bit 1 equals the old bit 0 and bit 2 equals the old bit 1.
- R4: With mode 2'b11 the register keeps its value across any number of edges, and both serial inputs have no effect.
- R5: tap_right_o always equals par_o bit 0 and tap_left_o always equals par_o bit 2, so a shift toward bit 0 drops the bit that tap_right_o showed and a shift toward the top bit drops the bit that tap_left_o showed.
- R6: Three edges in mode 2'b01 with serial bits a, b, c give par_o = {c, b, a}. Three edges in mode 2'b10 with bits a, b, c give par_o = {a, b, c}.
- R7: During a shift, the serial input of the other direction has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| mode_i | input | 2 | Action select: 00 clear, 01 shift toward bit 0, 10 shift toward top bit, 11 keep |
| ser_right_i | input | 1 | Serial bit entering the top bit on a shift toward bit 0 |
| ser_left_i | input | 1 | Serial bit entering bit 0 on a shift toward the top bit |
| par_o | output | WIDTH (3) | Parallel register contents |
| tap_right_o | output | 1 | Bit 0, dropped by the next shift toward bit 0 |
| tap_left_o | output | 1 | Top bit, dropped by the next shift toward the top bit |

## Verification
The assertions assume the mode input and both serial inputs are stable and known at each rising edge. They make no assumption about the register contents before the first edge, because the block has no reset. They only start judging once one edge has passed. The bench changes inputs only on falling edges and opens with a clear, so every expected value it computes starts from a known register. It then mixes directed clears, holds and three-bit serial loads with random mode and serial values from a seeded generator.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    typedef enum logic [1:0] {
        SHM_CLEAR = 2'b00,
        SHM_RIGHT = 2'b01,
        SHM_LEFT  = 2'b10,
        SHM_HOLD  = 2'b11
    } shm_e;

endpackage

// File: rtl/shreg_lane.sv
// Next-value selector for one bit position of the register.
module shreg_lane
    import shreg_pkg::*;
(
    input  shm_e mode_i,
    input  logic self_i,
    input  logic upper_i,
    input  logic lower_i,
    output logic next_o
);

    always_comb begin
        case (mode_i)
            SHM_CLEAR: next_o = 1'b0;
            SHM_RIGHT: next_o = upper_i;
            SHM_LEFT:  next_o = lower_i;
            SHM_HOLD:  next_o = self_i;
            default:   next_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/shreg_core.sv
// Register array: one lane per bit, two-process state update.
module shreg_core
    import shreg_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  shm_e             mode_i,
    input  logic             ser_right_i,
    input  logic             ser_left_i,
    output logic [WIDTH-1:0] bits_o
);

    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } state_t;

    state_t st_d, st_q;

    logic [WIDTH-1:0] upper_w;
    logic [WIDTH-1:0] lower_w;
    logic [WIDTH-1:0] lane_next;

    // Neighbour feeding each bit for the two shift directions.
    assign upper_w = {ser_right_i, st_q.bits[TOP:1]};
    assign lower_w = {st_q.bits[TOP-1:0], ser_left_i};

    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        shreg_lane lane_i (
            .mode_i  (mode_i),
            .self_i  (st_q.bits[i]),
            .upper_i (upper_w[i]),
            .lower_i (lower_w[i]),
            .next_o  (lane_next[i])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.bits = lane_next;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bits_o = st_q.bits;

    // Assertion qualifier: the block has no reset, so checks start after one edge.
    logic primed_q = 1'b0;
    always_ff @(posedge clk) begin
        primed_q <= 1'b1;
    end

    assert_clear_R1: assert property (@(posedge clk) disable iff (!primed_q)
        (mode_i == SHM_CLEAR) |=> (bits_o == '0));

    assert_shift_right_R2: assert property (@(posedge clk) disable iff (!primed_q)
        (mode_i == SHM_RIGHT) |=>
            (bits_o == {$past(ser_right_i), $past(bits_o[TOP:1])}));

    assert_shift_left_R3: assert property (@(posedge clk) disable iff (!primed_q)
        (mode_i == SHM_LEFT) |=>
            (bits_o == {$past(bits_o[TOP-1:0]), $past(ser_left_i)}));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!primed_q)
        (mode_i == SHM_HOLD) |=> $stable(bits_o));

endmodule

// File: rtl/mode_shift_reg.sv
// Top: mode-selectable shift register with end-bit taps.
module mode_shift_reg
    import shreg_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic [1:0]       mode_i,
    input  logic             ser_right_i,
    input  logic             ser_left_i,
    output logic [WIDTH-1:0] par_o,
    output logic             tap_right_o,
    output logic             tap_left_o
);

    localparam int TOP = WIDTH - 1;

    shm_e mode_w;
    assign mode_w = shm_e'(mode_i);

    shreg_core #(.WIDTH(WIDTH)) core_i (
        .clk         (clk),
        .mode_i      (mode_w),
        .ser_right_i (ser_right_i),
        .ser_left_i  (ser_left_i),
        .bits_o      (par_o)
    );

    assign tap_right_o = par_o[0];
    assign tap_left_o  = par_o[TOP];

    logic primed_q = 1'b0;
    always_ff @(posedge clk) begin
        primed_q <= 1'b1;
    end

    // A left shift brings ser_left_i straight out on the right tap (R5, R7).
    assert_left_tap_R5: assert property (@(posedge clk) disable iff (!primed_q)
        (mode_w == SHM_LEFT) |=> (tap_right_o == $past(ser_left_i)));

    // A right shift brings ser_right_i straight out on the left tap (R5, R7).
    assert_right_tap_R7: assert property (@(posedge clk) disable iff (!primed_q)
        (mode_w == SHM_RIGHT) |=> (tap_left_o == $past(ser_right_i)));

endmodule

// File: tb/mode_shift_reg_tb_top.sv
`timescale 1ns/1ps
module mode_shift_reg_tb_top;

    localparam int W = 3;
    localparam int MAXCYC = 200000;

    logic         clk = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic         sr = 1'b0;
    logic         sl = 1'b0;
    logic [W-1:0] par;
    logic         tap_r, tap_l;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_q = '0;

    always #4 clk = ~clk;

    mode_shift_reg #(.WIDTH(W)) dut_i (
        .clk         (clk),
        .mode_i      (mode),
        .ser_right_i (sr),
        .ser_left_i  (sl),
        .par_o       (par),
        .tap_right_o (tap_r),
        .tap_left_o  (tap_l)
    );

    function automatic logic [W-1:0] model_next(logic [W-1:0] cur, logic [1:0] m,
                                                logic r, logic l);
        case (m)
            2'b00:   return '0;
            2'b01:   return {r, cur[W-1:1]};
            2'b10:   return {cur[W-2:0], l};
            default: return cur;
        endcase
    endfunction

    task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b expected %b", tag, got, exp);
        end
    endtask

    // Drive on the falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic step(logic [1:0] m, logic r, logic l);
        mode = m; sr = r; sl = l;
        @(posedge clk);
        exp_q = model_next(exp_q, m, r, l);
        @(negedge clk);
        check("R5 taps", {tap_l, 1'b0, tap_r}, {exp_q[W-1], 1'b0, exp_q[0]});
    endtask

    task automatic load_value(logic [W-1:0] v);
        for (int k = W - 1; k >= 0; k--) step(2'b10, 1'b0, v[k]);
    endtask

    initial begin
        #(8 * MAXCYC);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);

        // Initial clear gives a known state (R1).
        step(2'b00, 1'b1, 1'b1);
        check("R1 initial clear", par, 3'b000);

        // Clear from every value, serial inputs set high (R1).
        for (int v = 0; v < 8; v++) begin
            load_value(v[W-1:0]);
            check("R3 loaded value", par, v[W-1:0]);
            step(2'b00, 1'b1, 1'b1);
            check("R1 clear from value", par, 3'b000);
        end

        // Serial-to-parallel in both directions for every pattern (R6, R2, R3, R7).
        for (int p = 0; p < 8; p++) begin
            step(2'b00, 1'b0, 1'b0);
            for (int k = 0; k < W; k++) step(2'b01, p[k], ~p[k]);
            check("R6 right load", par, {p[2], p[1], p[0]});
            check("R2 right model", par, exp_q);
            step(2'b00, 1'b0, 1'b0);
            for (int k = 0; k < W; k++) step(2'b10, ~p[k], p[k]);
            check("R6 left load", par, {p[0], p[1], p[2]});
            check("R7 left ignores ser_right", par, exp_q);
        end

        // Shift out ends: bits leave through the taps (R5, R2, R3).
        load_value(3'b101);
        step(2'b01, 1'b0, 1'b1);
        check("R2 shift right drop", par, 3'b010);
        step(2'b10, 1'b1, 1'b0);
        check("R3 shift left drop", par, 3'b100);

        // Hold keeps a value for several edges with toggling serial inputs (R4).
        for (int v = 1; v < 8; v += 3) begin
            load_value(v[W-1:0]);
            for (int c = 0; c < 5; c++) begin
                step(2'b11, c[0], ~c[0]);
                check("R4 hold", par, v[W-1:0]);
            end
        end

        // Random mix against the model (R1..R4, R7).
        for (int n = 0; n < 400; n++) begin
            logic [1:0] m;
            m = 2'($urandom_range(0, 3));
            step(m, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            check("R2 R3 R4 R1 random", par, exp_q);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule